// File: doc/BRIEF.md
# Iterative Normalize Sequencer

This block normalizes a 31-bit signed quantity held across an A/B register pair. The sign sits in the top bit of A. The magnitude runs through the lower 15 bits of A and then the lower 15 bits of B. The top bit of B is not part of the number. After a start pulse the block takes in both words. It then shifts the pair left by one position per clock for as long as the two highest bits of A agree, and it counts each shift.

Shifting ends when the two top bits of A disagree. It also ends when the counter reaches its hard limit of 32, which is what a zero operand does. At that point the block raises a one-cycle done pulse. In the same cycle it raises a write strobe carrying a 6-bit count toward an external shift-count holder. Bit 5 (weight 32) of that count is always written as zero, so a zero operand leaves a stored count of 0.

The shifted words stay on the outputs until the next accepted start.

Top module: `norm_sequencer`

## Requirements
- R1: After reset, busy, done and cntWrEn are 0, and aOut, bOut and cntWrData are 0.
- R2: A start seen while idle captures aIn and bIn. Busy is 1 from the following cycle until the cycle of the done pulse.
- R3: The pair is shifted left once per busy cycle while aOut bit 15 equals aOut bit 14. When they differ, shifting stops and the final words are held on aOut/bOut.
- R4: Each shift is applied to both words. A bits 14..0 move to bits 15..1, B bit 14 enters A bit 0, B bits 13..0 move to bits 14..1, B bit 0 becomes 0, and B bit 15 keeps its value.
- R5: For a non-zero operand, the count written equals the number of shifts (0 to 31). An operand whose A bits 15 and 14 already differ finishes with count 0 and unchanged words.
- R6: A zero operand stops after exactly 32 shifts and writes a count of 0.
- R7: Bit 5 of cntWrData is 0 on every write.
- R8: done and cntWrEn are high together for exactly one cycle per operation.
- R9: A start that arrives while busy is 1 has no effect on the operation in progress or its results.
- R10: With k shifts, done is high after the (k+2)th rising edge, counting the edge that accepts start as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, single-cycle pulse |
| aIn | input | 16 | A word to normalize |
| bIn | input | 16 | B word to normalize |
| aOut | output | 16 | Current or final A word |
| bOut | output | 16 | Current or final B word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| cntWrEn | output | 1 | Write strobe toward the shift-count holder |
| cntWrData | output | 6 | Shift count to store, bit 5 always 0 |

## Verification
A wrong shift condition or a wrong bit routing shows in aOut/bOut, which the bench compares with a model when done rises. A counter that miscounts or misses the limit of 32 shows in two ways: the done pulse arrives on the wrong cycle, and the count value is wrong. Both are checked in the cycle the pulse is expected. A start that leaks into a busy operation changes the final words or the timing, and both are visible by the end of that operation.

// File: rtl/norm_pkg.sv
package norm_pkg;
  typedef struct packed {
    logic load;    // capture fresh operands and clear the counter
    logic shift;   // one left shift of the pair, counter + 1
    logic finish;  // latch the count toward the holder
  } normStrobe_t;
endpackage

// File: rtl/norm_datapath.sv
module norm_datapath
  import norm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int STOP_COUNT = 32,
  parameter int CNT_W      = $clog2(STOP_COUNT) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  normStrobe_t       strb,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] aReg,
  output logic [DATA_W-1:0] bReg,
  output logic [CNT_W-1:0]  cntData,
  output logic              topEqual,
  output logic              cntFull
);
  localparam int MAG_TOP = DATA_W - 2;  // highest magnitude bit of a word

  logic [CNT_W-1:0] shiftCnt;

  assign topEqual = (aReg[DATA_W-1] == aReg[DATA_W-2]);
  assign cntFull  = (shiftCnt == CNT_W'(STOP_COUNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      bReg     <= '0;
      shiftCnt <= '0;
      cntData  <= '0;
    end else begin
      if (strb.load) begin
        aReg     <= aIn;
        bReg     <= bIn;
        shiftCnt <= '0;
      end else if (strb.shift) begin
        aReg     <= {aReg[DATA_W-2:0], bReg[MAG_TOP]};
        bReg     <= {bReg[DATA_W-1], bReg[MAG_TOP-1:0], 1'b0};
        shiftCnt <= shiftCnt + 1'b1;
      end
      if (strb.finish)
        cntData <= {1'b0, shiftCnt[CNT_W-2:0]};
    end
  end
endmodule

// File: rtl/norm_control.sv
module norm_control
  import norm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        topEqual,
  input  logic        cntFull,
  output normStrobe_t strb,
  output logic        busy,
  output logic        donePulse
);
  logic stopNow;

  assign stopNow = !topEqual || cntFull;

  always_comb begin
    strb.load   = !busy && start;
    strb.shift  = busy && !stopNow;
    strb.finish = busy && stopNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= strb.finish;
      if (strb.load)
        busy <= 1'b1;
      else if (strb.finish)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/norm_sequencer.sv
module norm_sequencer
  import norm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int STOP_COUNT = 32,
  parameter int CNT_W      = $clog2(STOP_COUNT) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] aOut,
  output logic [DATA_W-1:0] bOut,
  output logic              busy,
  output logic              done,
  output logic              cntWrEn,
  output logic [CNT_W-1:0]  cntWrData
);
  normStrobe_t strb;
  logic        topEqual;
  logic        cntFull;
  logic        donePulse;

  norm_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .topEqual (topEqual),
    .cntFull  (cntFull),
    .strb     (strb),
    .busy     (busy),
    .donePulse(donePulse)
  );

  norm_datapath #(
    .DATA_W    (DATA_W),
    .STOP_COUNT(STOP_COUNT),
    .CNT_W     (CNT_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .aIn     (aIn),
    .bIn     (bIn),
    .aReg    (aOut),
    .bReg    (bOut),
    .cntData (cntWrData),
    .topEqual(topEqual),
    .cntFull (cntFull)
  );

  assign done    = donePulse;
  assign cntWrEn = donePulse;
endmodule

// File: rtl/norm_sequencer_checker.sv
module norm_sequencer_checker #(
  parameter int DATA_W     = 16,
  parameter int STOP_COUNT = 32,
  parameter int CNT_W      = $clog2(STOP_COUNT) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [DATA_W-1:0] aOut,
  input logic [DATA_W-1:0] bOut,
  input logic              busy,
  input logic              done,
  input logic              cntWrEn,
  input logic [CNT_W-1:0]  cntWrData
);
  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  // R6: a run never exceeds the limit shifts plus the stop cycle
  assert_run_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= STOP_COUNT + 1);

  assert_count_msb_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |-> !cntWrData[CNT_W-1]);

  assert_strobe_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    done == cntWrEn);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_ends_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_normalized_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (aOut[DATA_W-1] != aOut[DATA_W-2]) ||
             (aOut == '0 && bOut[DATA_W-2:0] == '0));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> (busy || done));
endmodule

bind norm_sequencer norm_sequencer_checker #(
  .DATA_W(DATA_W), .STOP_COUNT(STOP_COUNT), .CNT_W(CNT_W)
) u_checker (.*);

// File: tb/norm_sequencer_bench.sv
module norm_sequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] aIn = '0;
  logic [15:0] bIn = '0;
  logic [15:0] aOut, bOut;
  logic        busy, done, cntWrEn;
  logic [5:0]  cntWrData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  norm_sequencer u_norm_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .bOut(bOut), .busy(busy), .done(done),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Model built from R3..R6: shift while A15 == A14, limit 32
  task automatic model(input logic [15:0] a, input logic [15:0] b,
                       output logic [15:0] ea, output logic [15:0] eb,
                       output int k);
    ea = a; eb = b; k = 0;
    while (k < 32 && ea[15] == ea[14]) begin
      ea = {ea[14:0], eb[14]};
      eb = {eb[15], eb[13:0], 1'b0};
      k++;
    end
  endtask

  // Runs one operation; optionally pulses a stray start while busy (R9)
  task automatic runCase(input logic [15:0] a, input logic [15:0] b,
                         input bit stray, input string tag);
    logic [15:0] ea, eb;
    int k, n;
    bit seen;
    model(a, b, ea, eb, k);
    @(negedge clk);
    aIn = a; bIn = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", {tag, " busy after start"}, 32'(busy), 1);
    if (stray) begin
      aIn = ~a; bIn = ~b; start = 1'b1;  // R9 stray request
      @(negedge clk);
      start = 1'b0;
    end
    n = stray ? 2 : 1;
    seen = 1'b0;
    while (!seen && n < 40) begin
      if (done) seen = 1'b1;
      else begin @(negedge clk); n++; end
    end
    check(seen && n == k + 2, "R10", {tag, " done latency"}, 32'(n), 32'(k + 2));
    check(cntWrEn == 1'b1, "R8", {tag, " write strobe with done"}, 32'(cntWrEn), 1);
    check(aOut == ea, "R3", {tag, " A result"}, 32'(aOut), 32'(ea));
    check(bOut == eb, "R4", {tag, " B result"}, 32'(bOut), 32'(eb));
    check(cntWrData == 6'(k % 32), "R5", {tag, " count"}, 32'(cntWrData), 32'(k % 32));
    check(cntWrData[5] == 1'b0, "R7", {tag, " count bit 5"}, 32'(cntWrData[5]), 0);
    @(negedge clk);
    check(!done && !cntWrEn && !busy, "R8", {tag, " single pulse"},
          32'({busy, done, cntWrEn}), 0);
    check(aOut == ea && bOut == eb, "R3", {tag, " result held"},
          {aOut, bOut}, {ea, eb});
  endtask

  task automatic testReset;
    @(negedge clk);
    check(!busy && !done && !cntWrEn, "R1", "control outputs",
          32'({busy, done, cntWrEn}), 0);
    check(aOut == 0 && bOut == 0 && cntWrData == 0, "R1", "data outputs",
          {aOut, bOut}, 0);
  endtask

  task automatic testZero;
    runCase(16'h0000, 16'h0000, 1'b0, "R6 zero operand");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    runCase(16'h4000, 16'h0000, 1'b0, "R5 already normalized");
    runCase(16'hA123, 16'h1234, 1'b0, "R5 negative normalized");
    runCase(16'h0001, 16'h4000, 1'b0, "R4 B14 into A0");
    runCase(16'h0000, 16'h8001, 1'b0, "R4 B15 kept");
    runCase(16'hFFFF, 16'h0000, 1'b0, "R3 negative shift");
    runCase(16'h0000, 16'h0001, 1'b0, "R5 count 29");
    runCase(16'hFFFF, 16'hFFFF, 1'b0, "R5 count 30");
    testZero();
    runCase(16'h0003, 16'h5555, 1'b1, "R9 stray start");
    runCase(16'h0000, 16'h8000, 1'b0, "R6 zero with B15");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule